// File: doc/BRIEF.md
# Ordering table clear DMA

This block is a write-only DMA channel that prepares an empty, reverse-linked list in memory, ready for a later stage to fill in. A launch presents a control word, a start address and an entry count. When the control word carries the single run code, the channel writes one 32-bit entry per accepted memory cycle, moving toward lower addresses. Every entry holds a pointer to the entry one word below it. The lowest entry it writes holds an end marker instead of a pointer.

Any other control code makes the channel finish at once, with no memory traffic. On completion the channel clears its enable and trigger control bits and pulses an interrupt. The control word can be read back at all times. The memory side is a plain write request with a ready handshake. Arbitration and the consumers of the list are outside the block.

Top module: `otc_dma`

## Requirements
- R1: After reset, `mem_req_o`, `irq_o` and `busy_o` are 0 and `ctrl_o` is 0.
- R2: A launch whose control word is not exactly 0x11000002 causes no memory write. `irq_o` pulses in the cycle after the launch edge, and `ctrl_o` becomes the launched word with bits 24 and 28 cleared.
- R3: The first entry is written at the launched address with its two low bits forced to 0.
- R4: Each entry other than the last one, written at address A, carries the data (A - 4) & 0xFFFFFF with bits 31:24 zero. Each accepted write moves the next address down by 4, at one entry per accepted cycle.
- R5: The lowest entry written carries 0x00FFFFFF. A count of 1 writes only that end marker, at the start address.
- R6: The count is taken directly as the number of entries, with no block multiplication. A count of N writes exactly N entries when the start address is at least 4·N.
- R7: A count of 0 writes 2^CW entries, the largest count the count field can express.
- R8: The channel never writes below address 4, except for a start address of 0. When the walk reaches address 4 before the count runs out, that entry takes the end marker and the run ends. A start address of 0 writes a single end marker at address 0.
- R9: While `mem_req_o` is high and `mem_rdy_i` is low, the address and data hold steady and no progress is made.
- R10: `irq_o` is a one-cycle pulse in the cycle after the last accepted write. At that point `ctrl_o` equals the launched word with bits 24 and 28 cleared (0x00000002 after a run).
- R11: A launch while `busy_o` is high is ignored. The running fill, its entries and `ctrl_o` are unchanged, and no extra interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Launch strobe, sampled on the clock edge |
| launch_ctrl_i | input | 32 | Control word captured at launch |
| launch_addr_i | input | AW | Start (highest) address of the list |
| launch_count_i | input | CW | Entry count, 0 meaning 2^CW |
| ctrl_o | output | 32 | Current control word |
| busy_o | output | 1 | Fill in progress |
| irq_o | output | 1 | Completion pulse |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | 32 | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts the current write |

## Verification
The first write request appears one cycle after the launch edge. Each later entry appears in the cycle after the previous write was accepted. The interrupt is due one cycle after the last accepted write, or one cycle after the launch edge for a rejected control word. The bench numbers the cycles on the rising edge and samples on the falling edge. A monitor pops the expected address and data from a scoreboard queue on every accepted write. The completion check then compares the interrupt cycle with the recorded cycles of the launch and of the last accepted write.

// File: rtl/otc_pkg.sv
package otc_pkg;
  localparam logic [31:0] CTRL_RUN_CODE  = 32'h1100_0002;
  localparam logic [31:0] CTRL_DONE_MASK = 32'h1100_0000;
  localparam int          LINK_W         = 24;
  localparam logic [LINK_W-1:0] LINK_END = 24'hFF_FFFF;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } walk_state_e;
endpackage

// File: rtl/otc_cfg.sv
module otc_cfg
  import otc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic [31:0] launch_ctrl_i,
  input  logic        idle_i,
  input  logic        fill_done_i,
  output logic        go_o,
  output logic [31:0] ctrl_o,
  output logic        irq_o
);
  logic        accept;
  logic        ctrl_en;
  logic [31:0] ctrl_d, ctrl_q;
  logic        irq_d, irq_q;

  always_comb begin
    accept  = launch_i && idle_i;
    go_o    = accept && (launch_ctrl_i == CTRL_RUN_CODE);
    ctrl_en = accept || fill_done_i;
    ctrl_d  = ctrl_q;
    if (accept) begin
      ctrl_d = go_o ? launch_ctrl_i : (launch_ctrl_i & ~CTRL_DONE_MASK);
    end else if (fill_done_i) begin
      ctrl_d = ctrl_q & ~CTRL_DONE_MASK;
    end
    irq_d = (accept && !go_o) || fill_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      irq_q <= irq_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/otc_walker.sv
module otc_walker
  import otc_pkg::*;
#(
  parameter int AW = 21,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          rdy_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          done_o,
  output logic          idle_o
);
  localparam int            RW    = CW + 1;
  localparam logic [RW-1:0] FULL  = RW'(1) << CW;
  localparam logic [RW-1:0] ONE   = RW'(1);
  localparam logic [AW-1:0] STEP  = AW'(4);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  walk_state_e   state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          fill, fire, pos_en;

  always_comb begin
    fill   = (state_q == ST_FILL);
    fire   = fill && rdy_i;
    last_o = fill && ((rem_q == ONE) || (cur_q <= STEP));
    done_o = fire && last_o;

    state_d = state_q;
    if (start_i)     state_d = ST_FILL;
    else if (done_o) state_d = ST_IDLE;

    cur_d  = cur_q;
    rem_d  = rem_q;
    pos_en = start_i || fire;
    if (start_i) begin
      cur_d = addr_i & ALIGN;
      rem_d = (count_i == '0) ? FULL : {1'b0, count_i};
    end else if (fire && !last_o) begin
      cur_d = cur_q - STEP;
      rem_d = rem_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pos_en) begin
        cur_q <= cur_d;
        rem_q <= rem_d;
      end
    end
  end

  assign req_o  = fill;
  assign addr_o = cur_q;
  assign idle_o = !fill;
endmodule

// File: rtl/otc_entry_gen.sv
module otc_entry_gen
  import otc_pkg::*;
#(
  parameter int AW = 21
)(
  input  logic [AW-1:0] cur_i,
  input  logic          last_i,
  output logic [31:0]   data_o
);
  logic [LINK_W-1:0] cur_link;
  logic [LINK_W-1:0] below_link;

  always_comb begin
    cur_link   = LINK_W'(cur_i);
    below_link = cur_link - LINK_W'(4);
    data_o     = {8'h00, last_i ? LINK_END : below_link};
  end
endmodule

// File: rtl/otc_dma.sv
module otc_dma
  import otc_pkg::*;
#(
  parameter int AW = 21,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic [31:0]   launch_ctrl_i,
  input  logic [AW-1:0] launch_addr_i,
  input  logic [CW-1:0] launch_count_i,
  output logic [31:0]   ctrl_o,
  output logic          busy_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_data_o,
  input  logic          mem_rdy_i
);
  logic go, idle, last, fill_done;

  otc_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch_i),
    .launch_ctrl_i(launch_ctrl_i),
    .idle_i       (idle),
    .fill_done_i  (fill_done),
    .go_o         (go),
    .ctrl_o       (ctrl_o),
    .irq_o        (irq_o)
  );

  otc_walker #(.AW(AW), .CW(CW)) u_walker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(go),
    .addr_i (launch_addr_i),
    .count_i(launch_count_i),
    .rdy_i  (mem_rdy_i),
    .req_o  (mem_req_o),
    .addr_o (mem_addr_o),
    .last_o (last),
    .done_o (fill_done),
    .idle_o (idle)
  );

  otc_entry_gen #(.AW(AW)) u_entry (
    .cur_i (mem_addr_o),
    .last_i(last),
    .data_o(mem_data_o)
  );

  assign busy_o = !idle;
endmodule

// File: rtl/otc_dma_chk.sv
module otc_dma_chk #(
  parameter int AW = 21
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          irq_o,
  input logic [31:0]   ctrl_o,
  input logic          mem_req_o,
  input logic          mem_rdy_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_data_o
);
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o); // R2

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) - AW'(4)))); // R4

  AST_FLOOR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_addr_o == '0) |-> (mem_data_o == 32'h00FF_FFFF)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R9

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R10

  AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!ctrl_o[24] && !ctrl_o[28] && !busy_o)); // R10
endmodule

bind otc_dma otc_dma_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .irq_o     (irq_o),
  .ctrl_o    (ctrl_o),
  .mem_req_o (mem_req_o),
  .mem_rdy_i (mem_rdy_i),
  .mem_addr_o(mem_addr_o),
  .mem_data_o(mem_data_o)
);

// File: tb/test_otc_dma.sv
`timescale 1ns/1ps
module test_otc_dma;
  localparam int AW = 21;
  localparam int CW = 10;
  localparam logic [31:0] RUN = 32'h1100_0002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_i = 1'b0;
  logic [31:0]   launch_ctrl_i = '0;
  logic [AW-1:0] launch_addr_i = '0;
  logic [CW-1:0] launch_count_i = '0;
  logic [31:0]   ctrl_o;
  logic          busy_o, irq_o, mem_req_o, mem_rdy_i;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_data_o;

  otc_dma #(.AW(AW), .CW(CW)) i_otc_dma (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int last_acc_cyc = -1;
  int launch_cyc = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;
  logic [63:0] sb[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(posedge clk);
    #1;
    mem_rdy_i = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor: pops the scoreboard on each accepted write
  initial begin
    bit prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall && mem_req_o) begin
          chk(mem_addr_o == prev_addr && mem_data_o == prev_data, "R9 stall hold",
              {11'd0, mem_addr_o, mem_data_o}, {11'd0, prev_addr, prev_data});
        end
        if (mem_req_o && mem_rdy_i) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R6 unexpected write", {11'd0, mem_addr_o, mem_data_o}, 64'd0);
          end else begin
            logic [63:0] e;
            e = sb.pop_front();
            chk({11'd0, mem_addr_o, mem_data_o} == e, "R4/R5 entry", {11'd0, mem_addr_o, mem_data_o}, e);
          end
          last_acc_cyc = cyc;
        end
        prev_stall = mem_req_o && !mem_rdy_i;
        prev_addr  = mem_addr_o;
        prev_data  = mem_data_o;
      end
    end
  end

  task automatic kick(input logic [31:0] c, input logic [AW-1:0] a, input int n);
    if (c == RUN) begin
      longint cur = longint'(a) & ~longint'(3);
      int cnt = (n == 0) ? (1 << CW) : n;
      for (int k = 0; k < cnt; k++) begin
        if (k == cnt - 1 || cur <= 4) begin
          sb.push_back({cur[31:0], 32'h00FF_FFFF});
          break;
        end
        sb.push_back({cur[31:0], 32'((cur - 4) & 64'hFF_FFFF)});
        cur = cur - 4;
      end
    end
    @(posedge clk);
    #1;
    launch_ctrl_i  = c;
    launch_addr_i  = a;
    launch_count_i = CW'(n);
    launch_i       = 1'b1;
    launch_cyc     = cyc;
    @(posedge clk);
    #1;
    launch_i = 1'b0;
  endtask

  task automatic wait_done(input string req, input bit rejected, input logic [31:0] exp_ctrl);
    int irq_cyc = -1;
    for (int t = 0; t < 20000 && irq_cyc < 0; t++) begin
      @(negedge clk);
      if (irq_o) irq_cyc = cyc;
    end
    chk(irq_cyc >= 0, {req, " R10 irq seen"}, 64'(irq_cyc), 64'd1);
    if (rejected)
      chk(irq_cyc == launch_cyc + 1, {req, " R2 irq timing"}, 64'(irq_cyc), 64'(launch_cyc + 1));
    else
      chk(irq_cyc == last_acc_cyc + 1, {req, " R10 irq timing"}, 64'(irq_cyc), 64'(last_acc_cyc + 1));
    chk(sb.size() == 0, {req, " R6 all entries written"}, 64'(sb.size()), 64'd0);
    chk(ctrl_o == exp_ctrl, {req, " R10 ctrl"}, 64'(ctrl_o), 64'(exp_ctrl));
    @(negedge clk);
    chk(!irq_o && !mem_req_o, {req, " R10 one-cycle irq"}, {62'd0, irq_o, mem_req_o}, 64'd0);
    sb.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !irq_o && !busy_o && ctrl_o == 32'd0, "R1 reset",
        {ctrl_o, 29'd0, mem_req_o, irq_o, busy_o}, 64'd0);

    kick(32'h0100_0201, 21'h400, 4);
    wait_done("R2 bad ctrl", 1'b1, 32'h0000_0201);

    kick(RUN, 21'h1000, 5);
    @(negedge clk);
    chk(busy_o && mem_req_o && mem_addr_o == 21'h1000, "R4 first write one cycle after launch",
        {11'd0, mem_addr_o, 30'd0, busy_o, mem_req_o}, {11'd0, 21'h1000, 32'd3});
    wait_done("R4 R6 five entries", 1'b0, 32'h0000_0002);

    kick(RUN, 21'h2003, 3);
    wait_done("R3 unaligned start", 1'b0, 32'h0000_0002);

    kick(RUN, 21'h3000, 1);
    wait_done("R5 single end marker", 1'b0, 32'h0000_0002);

    kick(RUN, 21'h10000, 0);
    wait_done("R7 zero count", 1'b0, 32'h0000_0002);

    kick(RUN, 21'h10, 20);
    wait_done("R8 floor stop", 1'b0, 32'h0000_0002);

    kick(RUN, 21'h0, 4);
    wait_done("R8 start at zero", 1'b0, 32'h0000_0002);

    stall_mode = 1'b1;
    kick(RUN, 21'h5000, 40);
    wait_done("R9 stalled fill", 1'b0, 32'h0000_0002);

    // R11: launch while busy must be ignored
    kick(RUN, 21'h6000, 30);
    repeat (4) @(posedge clk);
    #1;
    launch_ctrl_i = 32'h0000_0007;
    launch_addr_i = 21'h100;
    launch_count_i = CW'(2);
    launch_i = 1'b1;
    @(posedge clk);
    #1 launch_i = 1'b0;
    @(negedge clk);
    chk(!irq_o && busy_o && ctrl_o == RUN, "R11 busy launch ignored",
        {ctrl_o, 30'd0, irq_o, busy_o}, {RUN, 32'd1});
    wait_done("R11 fill unchanged", 1'b0, 32'h0000_0002);
    stall_mode = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule